// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer with Capture

The block is a down-counting timer with two companion registers, RA and RB, and two input pins, A and B. A three-bit mode field, written as {C3,C2,C1}, picks one of three behaviours. As a pulse generator, the timer runs from the master clock and reloads alternately from RA and RB. As an event counter, it decrements once for each chosen edge on pin A. As a dual capture unit, it runs from the master clock and copies its value into RA or RB when a chosen edge arrives on pin A or pin B. Two sticky interrupt flags report reloads, underflows and captures. Software clears a flag by writing 1 to it.

Both pins pass through a two-flop synchronizer before edge detection. The block keeps counting while the processor clock is stopped only if two bits are set: a high-speed select bit and an idle-run bit. While idle running is configured, the toggling pulse mode is refused.

Software reaches the block through a write-only port with four locations. Location 0 is the counter, location 1 is RA, location 2 is RB, and location 3 is control. The control fields are: bits [2:0] mode, bit 3 run, bit 4 high-speed select, bit 5 idle-run enable, bit 6 clear flag A, and bit 7 clear flag B. The counter and both registers are visible on output ports.

Top module: `mm_timer`

## Requirements
- R1: After reset the counter, RA, RB, both flags and the pulse output are 0 and the timer is stopped. A write to location 0, 1 or 2 loads the counter, RA or RB on the next clock edge, and a bus write takes priority over any timer update in the same cycle.
- R2: Modes 000 and 001 are event counter modes. The counter decrements by one for each rising edge on pin A in mode 000 and for each falling edge on pin A in mode 001. Edges of the other polarity have no effect.
- R3: In the event counter and capture modes, a decrement from 0 reloads the counter from RA and sets flag A. In the event counter modes, a rising edge on pin B sets flag B.
- R4: Modes 100 and 101 are pulse modes. The counter decrements on every master clock. Each time the counter leaves 0 it reloads, alternating between RB and RA. Reloading from RB sets flag B and reloading from RA sets flag A. A write to the counter starts a new RA period, and a period lasts its reload value plus one clocks.
- R5: The pulse output is high only in mode 101 while the timer is running and in an RA period. It is low during RB periods and is always low in mode 100 and in every other mode.
- R6: Modes with C2=1 are capture modes, and the counter decrements on every master clock. C1 selects the pin A capture edge (0 rising, 1 falling) and C3 selects the pin B capture edge (0 rising, 1 falling). A selected A edge copies the counter value into RA and a selected B edge copies it into RB. Edges that are not selected capture nothing.
- R7: In capture modes, a selected A edge sets flag A and a selected B edge sets flag B.
- R8: The timer advances only while run is 1 and either cpu_clk_on is 1 or both the high-speed select bit and the idle-run bit are 1. Otherwise the counter holds its value.
- R9: When both the high-speed select bit and the idle-run bit are 1, mode 101 is refused and the counter holds.
- R10: The flags stay set until a control write has a 1 in bit 6 (flag A) or bit 7 (flag B). A write of 0 in those bits leaves the flags unchanged.
- R11: Each pin transition produces exactly one count or capture, taking effect on the third clock edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_clk_on | input | 1 | High while the processor clock is running |
| pin_a | input | 1 | Asynchronous pin A |
| pin_b | input | 1 | Asynchronous pin B |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write location: 0 counter, 1 RA, 2 RB, 3 control |
| wr_data | input | W | Write data |
| timer_q | output | W | Counter value |
| ra_q | output | W | RA register |
| rb_q | output | W | RB register |
| irq_a | output | 1 | Pending flag A |
| irq_b | output | 1 | Pending flag B |
| pwm_out | output | 1 | Pulse output |

## Verification
All internal state is visible at the ports on the cycle after it changes, so errors show up quickly. A wrong pulse phase bit shows up at the next reload as the wrong register loaded and the wrong flag raised, and in mode 101 the pulse output inverts at the same time. A synchronizer or edge-detector fault shows up as a missed or doubled count within four clocks of a pin transition. A wrong capture polarity leaves RA or RB unchanged, or changes it on the wrong transition, on the same edge that should have set the flag.

// File: rtl/mm_timer.sv
module mm_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpu_clk_on,
  input  logic         pin_a,
  input  logic         pin_b,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] timer_q,
  output logic [W-1:0] ra_q,
  output logic [W-1:0] rb_q,
  output logic         irq_a,
  output logic         irq_b,
  output logic         pwm_out
);

  logic [2:0] mode;
  logic       run, hs_sel, idle_en, ph_b;
  logic [2:0] sa, sb;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sa <= '0;
      sb <= '0;
    end else begin
      sa <= {sa[1:0], pin_a};
      sb <= {sb[1:0], pin_b};
    end

  wire rise_a = sa[1] & ~sa[2];
  wire fall_a = ~sa[1] & sa[2];
  wire rise_b = sb[1] & ~sb[2];
  wire fall_b = ~sb[1] & sb[2];

  wire wr_t   = wr_en & (wr_addr == 2'd0);
  wire wr_ra  = wr_en & (wr_addr == 2'd1);
  wire wr_rb  = wr_en & (wr_addr == 2'd2);
  wire wr_ctl = wr_en & (wr_addr == 2'd3);

  wire idle_cfg = hs_sel & idle_en;
  wire refuse   = idle_cfg & (mode == 3'b101);
  wire tick     = run & (cpu_clk_on | idle_cfg) & ~refuse;

  wire is_evt = (mode[2:1] == 2'b00);
  wire is_pwm = (mode[2:1] == 2'b10);
  wire is_cap = mode[1];

  wire a_sel = mode[0] ? fall_a : rise_a;
  wire b_sel = mode[2] ? fall_b : rise_b;

  wire dec = tick & (is_evt ? a_sel : 1'b1);
  wire uf  = dec & (timer_q == '0);

  wire cap_a = tick & is_cap & a_sel;
  wire cap_b = tick & is_cap & b_sel;

  wire set_a = (uf & (~is_pwm | ph_b)) | cap_a;
  wire set_b = (uf & is_pwm & ~ph_b) | cap_b | (tick & is_evt & rise_b);
  wire clr_a = wr_ctl & wr_data[6];
  wire clr_b = wr_ctl & wr_data[7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode    <= '0;
      run     <= 1'b0;
      hs_sel  <= 1'b0;
      idle_en <= 1'b0;
    end else if (wr_ctl) begin
      mode    <= wr_data[2:0];
      run     <= wr_data[3];
      hs_sel  <= wr_data[4];
      idle_en <= wr_data[5];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      timer_q <= '0;
      ph_b    <= 1'b0;
    end else if (wr_t) begin
      timer_q <= wr_data;
      ph_b    <= 1'b0;
    end else if (uf) begin
      if (is_pwm) begin
        timer_q <= ph_b ? ra_q : rb_q;
        ph_b    <= ~ph_b;
      end else begin
        timer_q <= ra_q;
      end
    end else if (dec) begin
      timer_q <= timer_q - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     ra_q <= '0;
    else if (wr_ra) ra_q <= wr_data;
    else if (cap_a) ra_q <= timer_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     rb_q <= '0;
    else if (wr_rb) rb_q <= wr_data;
    else if (cap_b) rb_q <= timer_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_a <= 1'b0;
      irq_b <= 1'b0;
    end else begin
      irq_a <= set_a | (irq_a & ~clr_a);
      irq_b <= set_b | (irq_b & ~clr_b);
    end

  assign pwm_out = (mode == 3'b101) & run & ~ph_b;

endmodule

// File: rtl/mm_timer_chk.sv
module mm_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         run,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic [W-1:0] wr_data,
  input logic [2:0]   mode,
  input logic [W-1:0] timer_q,
  input logic [W-1:0] ra_q,
  input logic         irq_a,
  input logic         irq_b,
  input logic         pwm_out
);

  // R8
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(timer_q));

  // R5
  pwm_mode_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_out |-> (mode == 3'b101 && run));

  // R10
  flag_a_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_a && !(wr_en && wr_addr == 2'd3 && wr_data[6])) |=> irq_a);

  // R10
  flag_b_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_b && !(wr_en && wr_addr == 2'd3 && wr_data[7])) |=> irq_b);

  // R2
  evt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2:1] == 2'b00 && !wr_en) |=>
      (timer_q == $past(timer_q) || timer_q == W'($past(timer_q) - 1'b1) ||
       timer_q == $past(ra_q)));

  // R6
  cap_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && !wr_en) |=> (ra_q == $past(ra_q) || ra_q == $past(timer_q)));

endmodule

bind mm_timer mm_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .mode(mode), .timer_q(timer_q),
  .ra_q(ra_q), .irq_a(irq_a), .irq_b(irq_b), .pwm_out(pwm_out)
);

// File: tb/tb_mm_timer.sv
module tb_mm_timer;
  localparam int W = 16;
  logic clk = 0, rst_n = 0, cpu_clk_on = 1, pin_a = 0, pin_b = 0, wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [W-1:0] wr_data = 0;
  logic [W-1:0] timer_q, ra_q, rb_q;
  logic irq_a, irq_b, pwm_out;
  int n_cmp = 0, n_bad = 0, cyc = 0;

  mm_timer #(.W(W)) dut (.*);

  always #5 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cap_step(input bit is_b, input bit lvl, input bit sel, input logic [7:0] cfg);
    logic [W-1:0] prev, c;
    wr(3, W'(cfg | 8'hC0));
    prev = is_b ? rb_q : ra_q;
    if (is_b) pin_b = lvl; else pin_a = lvl;
    @(negedge clk); @(negedge clk);
    c = timer_q;
    @(negedge clk);
    chk(is_b ? "R6 capB" : "R6 capA", is_b ? rb_q : ra_q, sel ? c : prev);
    chk(is_b ? "R7 flagB" : "R7 flagA", is_b ? irq_b : irq_a, sel);
  endtask

  initial begin
    #23 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 timer", timer_q, 0); chk("R1 ra", ra_q, 0); chk("R1 rb", rb_q, 0);
    chk("R1 irq", {irq_a, irq_b, pwm_out}, 0);
    wr(1, 16'h1234); wr(2, 16'hBEEF); wr(0, 16'h0042);
    chk("R1 ra wr", ra_q, 16'h1234); chk("R1 rb wr", rb_q, 16'hBEEF);
    chk("R1 timer wr", timer_q, 16'h0042);

    // R2 R3 R11 event modes
    for (int m = 0; m < 2; m++) begin
      int n;
      logic [7:0] cfg;
      cfg = 8'(8 + m);
      wr(3, 0); wr(1, 3); wr(0, 3); wr(3, W'(cfg | 8'hC0));
      n = 0;
      for (int i = 0; i < 10; i++) begin
        pin_a = 1; waitn(4);
        if (m == 0) n++;
        chk("R2 R11 evt rise", timer_q, 3 - (n % 4));
        chk("R3 uf flagA", irq_a, n >= 4);
        pin_a = 0; waitn(4);
        if (m == 1) n++;
        chk("R2 R11 evt fall", timer_q, 3 - (n % 4));
      end
      chk("R3 no flagB", irq_b, 0);
      pin_b = 1; waitn(4);
      chk("R3 B rise flag", irq_b, 1);
      wr(3, W'(cfg));
      chk("R10 zero write keeps", {irq_a, irq_b}, 2'b11);
      wr(3, W'(cfg | 8'h40));
      chk("R10 clear A", {irq_a, irq_b}, 2'b01);
      wr(3, W'(cfg | 8'h80));
      chk("R10 clear B", {irq_a, irq_b}, 2'b00);
      pin_b = 0; waitn(4);
      chk("R3 B fall no flag", irq_b, 0);
    end

    // R4 R5 pulse modes
    for (int m = 4; m < 6; m++) begin
      int t, rav, rbv;
      bit ph, ea, eb;
      rav = 2 + m; rbv = 3;
      wr(3, 0); wr(1, W'(rav)); wr(2, W'(rbv)); wr(0, W'(rav));
      wr(3, W'(8'hC0 | 8'(8 + m)));
      t = rav; ph = 0; ea = 0; eb = 0;
      chk("R5 pwm start", pwm_out, m == 5);
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (t == 0) begin
          if (ph) begin t = rav; ea = 1; end else begin t = rbv; eb = 1; end
          ph = !ph;
        end else t--;
        chk("R4 count", timer_q, t);
        chk("R4 flags", {irq_a, irq_b}, {ea, eb});
        chk("R5 pwm", pwm_out, (m == 5) && !ph);
      end
    end

    // R8 R9 idle gating
    wr(3, 0); wr(1, 500); wr(2, 500); wr(0, 500);
    cpu_clk_on = 0;
    wr(3, 8'h0C);
    begin
      logic [W-1:0] t0;
      t0 = timer_q; waitn(5);
      chk("R8 stopped cpu clk", timer_q, t0);
      wr(3, 8'h3C);
      t0 = timer_q; waitn(5);
      chk("R8 idle run", timer_q, t0 - 5);
      cpu_clk_on = 1;
      wr(3, 8'h3D);
      t0 = timer_q; waitn(5);
      chk("R9 refused", timer_q, t0);
      wr(3, 8'h0D);
      t0 = timer_q; waitn(5);
      chk("R9 allowed", timer_q, t0 - 5);
    end

    // R6 R7 capture modes
    for (int j = 0; j < 4; j++) begin
      logic [2:0] m;
      logic [7:0] cfg;
      bit af, bf;
      m = (j == 0) ? 3'b010 : (j == 1) ? 3'b110 : (j == 2) ? 3'b011 : 3'b111;
      af = m[0]; bf = m[2];
      cfg = {5'b00001, m};
      wr(3, 0); pin_a = 0; pin_b = 0; waitn(4);
      wr(1, 1000); wr(2, 1000); wr(0, 1000); wr(3, W'(cfg | 8'hC0));
      cap_step(0, 1, !af, cfg);
      cap_step(0, 0, af, cfg);
      cap_step(1, 1, !bf, cfg);
      cap_step(1, 0, bf, cfg);
    end

    // R3 capture-mode underflow
    wr(3, 0); wr(1, 2); wr(0, 2); wr(3, 8'hCA);
    waitn(3);
    chk("R3 cap uf reload", timer_q, 2);
    chk("R3 cap uf flag", irq_a, 1);

    summary();
  end
endmodule